// File: doc/BRIEF.md
# Full-Duplex PCM Sample Port

This block carries 16-bit audio samples in both directions at once between a pair of 32-entry FIFOs and a serial data line pair. A separate clock generator supplies a one-cycle bit strobe (one pulse per serial bit period) and a frame-start indication that is valid on a strobe cycle. On each frame the transmit side pops one sample and shifts it out MSB first. The receive side shifts in one sample and pushes it into its FIFO. For each direction, software chooses whether the MSB shares the strobe that carries the frame start or follows it by one bit period.

A small register port with a write strobe and a combinational read gives access to the control word, the transmit FIFO (write), the receive FIFO (read), the interrupt enables, the sticky interrupt status with its write-one-to-clear register, and a FIFO level report. Level-based DMA request lines and a single interrupt line complete the external view.

Top module: `pcm_port`

## Requirements
- R1: With a direction's MSB-late bit clear, the transmit MSB appears on `sdo` after the bit strobe that carries `frame_sync`, and the 15 remaining bits follow MSB first, one per strobe. After the sixteenth bit, `sdo` is 0.
- R2: With the MSB-late bit set, that direction's first bit moves one strobe later. The transmit and receive sides use independent bits: control bit 4 for transmit, bit 3 for receive.
- R3: The receive side samples `sdi` on the same strobes as R1/R2 and pushes the 16-bit word. A read of address 2 returns the word in bits [15:0] and pops it. Bit 16 is 1 when a word was present. A read of an empty FIFO returns 0 and sets receive-starvation status bit 1.
- R4: Control address 0 holds: bit0 global enable, bit1 RX FIFO enable, bit2 TX FIFO enable, bit5 RX DMA enable, bit6 TX DMA enable, [12:7] RX threshold and [18:13] TX threshold. A write that clears bit 0 while writing bit 1 or bit 2 as 1 leaves the global enable set.
- R5: Each FIFO holds 32 words. Address 5 reports the RX count in [5:0] and the TX count in [11:6]. Flags are at bits 12 to 15 (RX) and 16 to 19 (TX), in the order empty, almost-empty (count 4 or less), full, almost-full (count 28 or more).
- R6: A frame that starts with the TX FIFO empty sends all zeros and sets status bit 7.
- R7: A word written to address 1 while the TX FIFO is full is dropped and sets status bit 6. A word received while the RX FIFO is full is dropped and sets status bit 0. In both cases the stored words are unchanged.
- R8: The TX DMA request is high while its count is below the TX threshold. The RX DMA request is high while its count is nonzero and at least the RX threshold. Each also needs its DMA enable, its FIFO enable and the global enable.
- R9: Status at address 4 is sticky and is cleared by writing ones to address 6. Bits are: 0 RX overflow, 1 RX starve, 2 RX almost-full, 3 RX full, 4 RX almost-empty, 5 RX empty, and 6 to 11 the same set for TX. `irq` is high when master enable bit 12 of address 3 is set and some status bit is set with its enable bit in address 3 [11:0] set.
- R10: While a FIFO enable is clear, that FIFO is flushed to empty and writes to address 1 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_tick | input | 1 | One-cycle strobe per serial bit period |
| frame_sync | input | 1 | Frame start, valid while bit_tick is high |
| sdi | input | 1 | Serial receive data |
| sdo | output | 1 | Serial transmit data |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 19 | Register write data |
| rd_en | input | 1 | Register read strobe (pops the RX FIFO at address 2) |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 20 | Register read data, combinational |
| tx_dma_req | output | 1 | Transmit DMA request |
| rx_dma_req | output | 1 | Receive DMA request |
| irq | output | 1 | Interrupt request |

## Verification
The bench drives every combination of the two MSB-late bits, including mixed settings. A design that shared one framing bit, or was off by a strobe, would return shifted words on one side. It fills the TX FIFO through the almost-empty, almost-full and full edges, where an off-by-one compare would show the wrong flag at count 4, 5, 27 or 28. An overflow check confirms that a 33rd word does not overwrite stored data. An empty-frame starvation case must put out zeros and raise a clearable interrupt that stays quiet without the master enable. The global-enable write rule and FIFO flushing on disable are probed through readback.

// File: rtl/pcm_port_pkg.sv
package pcm_port_pkg;

    localparam int SAMPLE_W = 16;
    localparam int THR_W    = 6;
    localparam int RD_W     = 20;
    localparam int STAT_W   = 12;

    typedef enum logic [2:0] {
        A_CTRL     = 3'd0,
        A_TXDATA   = 3'd1,
        A_RXDATA   = 3'd2,
        A_IRQEN    = 3'd3,
        A_IRQSTAT  = 3'd4,
        A_FIFOSTAT = 3'd5,
        A_IRQCLR   = 3'd6
    } reg_addr_e;

    typedef struct packed {
        logic [THR_W-1:0] tx_thr;
        logic [THR_W-1:0] rx_thr;
        logic             tx_dma;
        logic             rx_dma;
        logic             tx_late;
        logic             rx_late;
        logic             tx_fifo;
        logic             rx_fifo;
        logic             en;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    typedef struct packed {
        logic empty;
        logic aempty;
        logic full;
        logic afull;
        logic starve;
        logic ovf;
    } dir_evt_t;

    typedef struct packed {
        logic afull;
        logic full;
        logic aempty;
        logic empty;
    } lvl_t;

endpackage

// File: rtl/pcm_fifo.sv
module pcm_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 32
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         flush,
    input  logic                         push,
    input  logic [W-1:0]                 din,
    input  logic                         pop,
    output logic [W-1:0]                 dout,
    output logic [$clog2(DEPTH+1)-1:0]   count,
    output logic                         full,
    output logic                         empty
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH+1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    logic          do_push, do_pop;

    function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
        return (p == AW'(DEPTH-1)) ? '0 : p + 1'b1;
    endfunction

    assign full    = (cnt == CW'(DEPTH));
    assign empty   = (cnt == '0);
    assign do_push = push & ~full;
    assign do_pop  = pop & ~empty;
    assign count   = cnt;
    assign dout    = mem[rp];

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= nxt(wp);
            if (do_pop)  rp <= nxt(rp);
            case ({do_push, do_pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= din;
    end

    assert_count_bound_R5: assert property (@(posedge clk) disable iff (rst)
        cnt <= CW'(DEPTH));

    assert_full_drop_R7: assert property (@(posedge clk) disable iff (rst)
        (push && full && !pop && !flush) |=> $stable(cnt));

endmodule

// File: rtl/pcm_tx_ser.sv
module pcm_tx_ser #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         active,
    input  logic         late,
    input  logic         bit_tick,
    input  logic         frame_sync,
    input  logic         fifo_empty,
    input  logic [W-1:0] fifo_data,
    output logic         fifo_pop,
    output logic         starve,
    output logic         sdo
);
    localparam int LW = $clog2(W+1);

    logic          sync_d;
    logic [W-1:0]  sh;
    logic [LW-1:0] left;
    logic          sdo_q;
    logic          start;
    logic [W-1:0]  ld_word;

    assign start    = active & bit_tick & (late ? sync_d : frame_sync);
    assign fifo_pop = start & ~fifo_empty;
    assign starve   = start & fifo_empty;
    assign ld_word  = fifo_empty ? '0 : fifo_data;
    assign sdo      = sdo_q;

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            sync_d <= 1'b0;
            sh     <= '0;
            left   <= '0;
            sdo_q  <= 1'b0;
        end else if (bit_tick) begin
            sync_d <= frame_sync;
            if (start) begin
                sdo_q <= ld_word[W-1];
                sh    <= {ld_word[W-2:0], 1'b0};
                left  <= LW'(W-1);
            end else if (left != '0) begin
                sdo_q <= sh[W-1];
                sh    <= {sh[W-2:0], 1'b0};
                left  <= left - 1'b1;
            end else begin
                sdo_q <= 1'b0;
            end
        end
    end

    assert_starve_zero_R6: assert property (@(posedge clk) disable iff (rst)
        (start && fifo_empty) |=> !sdo_q);

    assert_msb_first_R1: assert property (@(posedge clk) disable iff (rst)
        (start && !fifo_empty) |=> (sdo_q == $past(fifo_data[W-1])));

endmodule

// File: rtl/pcm_rx_ser.sv
module pcm_rx_ser #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         active,
    input  logic         late,
    input  logic         bit_tick,
    input  logic         frame_sync,
    input  logic         sdi,
    output logic         push,
    output logic [W-1:0] word
);
    localparam int LW = $clog2(W+1);

    logic          sync_d;
    logic [W-1:0]  sh;
    logic [LW-1:0] got;
    logic          start;

    assign start = active & bit_tick & (late ? sync_d : frame_sync);
    assign push  = active & bit_tick & ~start & (got == LW'(W-1));
    assign word  = {sh[W-2:0], sdi};

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            sync_d <= 1'b0;
            sh     <= '0;
            got    <= '0;
        end else if (bit_tick) begin
            sync_d <= frame_sync;
            if (start) begin
                sh  <= {{(W-1){1'b0}}, sdi};
                got <= LW'(1);
            end else if (got == LW'(W-1)) begin
                got <= '0;
            end else if (got != '0) begin
                sh  <= {sh[W-2:0], sdi};
                got <= got + 1'b1;
            end
        end
    end

    assert_bit_count_R3: assert property (@(posedge clk) disable iff (rst)
        got < LW'(W));

endmodule

// File: rtl/pcm_port.sv
module pcm_port
    import pcm_port_pkg::*;
#(
    parameter int FIFO_DEPTH = 32,
    parameter int AFULL_LVL  = 28,
    parameter int AEMPTY_LVL = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            bit_tick,
    input  logic            frame_sync,
    input  logic            sdi,
    output logic            sdo,
    input  logic            wr_en,
    input  logic [2:0]      wr_addr,
    input  logic [18:0]     wr_data,
    input  logic            rd_en,
    input  logic [2:0]      rd_addr,
    output logic [19:0]     rd_data,
    output logic            tx_dma_req,
    output logic            rx_dma_req,
    output logic            irq
);
    localparam int CW = $clog2(FIFO_DEPTH+1);

    ctrl_t               ctl_q, ctl_wr;
    logic [STAT_W:0]     ien_q;
    logic [STAT_W-1:0]   stat_q, evt, clr_mask;

    logic wr_ctl, wr_tx, wr_ien, wr_clr, rd_rx;

    logic [SAMPLE_W-1:0] tx_dout, rx_dout, rx_word;
    logic [CW-1:0]       tx_cnt, rx_cnt;
    logic tx_full, tx_empty, rx_full, rx_empty;
    logic tx_pop, tx_starve, rx_push;
    logic tx_act, rx_act;
    lvl_t tx_lvl, rx_lvl;
    dir_evt_t tx_evt, rx_evt;

    assign wr_ctl = wr_en && (reg_addr_e'(wr_addr) == A_CTRL);
    assign wr_tx  = wr_en && (reg_addr_e'(wr_addr) == A_TXDATA);
    assign wr_ien = wr_en && (reg_addr_e'(wr_addr) == A_IRQEN);
    assign wr_clr = wr_en && (reg_addr_e'(wr_addr) == A_IRQCLR);
    assign rd_rx  = rd_en && (reg_addr_e'(rd_addr) == A_RXDATA);

    // Global enable survives a clearing write while a FIFO stays enabled.
    always_comb begin
        ctl_wr    = ctrl_t'(wr_data);
        ctl_wr.en = wr_data[0] | (ctl_q.en & (wr_data[1] | wr_data[2]));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '0;
            ien_q <= '0;
        end else begin
            if (wr_ctl) ctl_q <= ctl_wr;
            if (wr_ien) ien_q <= wr_data[STAT_W:0];
        end
    end

    assign tx_act = ctl_q.en & ctl_q.tx_fifo;
    assign rx_act = ctl_q.en & ctl_q.rx_fifo;

    pcm_fifo #(.W(SAMPLE_W), .DEPTH(FIFO_DEPTH)) u_tx_fifo (
        .clk(clk), .rst(rst), .flush(~ctl_q.tx_fifo),
        .push(wr_tx & ctl_q.tx_fifo), .din(wr_data[SAMPLE_W-1:0]),
        .pop(tx_pop), .dout(tx_dout), .count(tx_cnt),
        .full(tx_full), .empty(tx_empty)
    );

    pcm_fifo #(.W(SAMPLE_W), .DEPTH(FIFO_DEPTH)) u_rx_fifo (
        .clk(clk), .rst(rst), .flush(~ctl_q.rx_fifo),
        .push(rx_push), .din(rx_word),
        .pop(rd_rx), .dout(rx_dout), .count(rx_cnt),
        .full(rx_full), .empty(rx_empty)
    );

    pcm_tx_ser #(.W(SAMPLE_W)) u_tx_ser (
        .clk(clk), .rst(rst), .active(tx_act), .late(ctl_q.tx_late),
        .bit_tick(bit_tick), .frame_sync(frame_sync),
        .fifo_empty(tx_empty), .fifo_data(tx_dout),
        .fifo_pop(tx_pop), .starve(tx_starve), .sdo(sdo)
    );

    pcm_rx_ser #(.W(SAMPLE_W)) u_rx_ser (
        .clk(clk), .rst(rst), .active(rx_act), .late(ctl_q.rx_late),
        .bit_tick(bit_tick), .frame_sync(frame_sync), .sdi(sdi),
        .push(rx_push), .word(rx_word)
    );

    always_comb begin
        tx_lvl.empty  = tx_empty;
        tx_lvl.full   = tx_full;
        tx_lvl.aempty = tx_cnt <= CW'(AEMPTY_LVL);
        tx_lvl.afull  = tx_cnt >= CW'(AFULL_LVL);
        rx_lvl.empty  = rx_empty;
        rx_lvl.full   = rx_full;
        rx_lvl.aempty = rx_cnt <= CW'(AEMPTY_LVL);
        rx_lvl.afull  = rx_cnt >= CW'(AFULL_LVL);

        tx_evt.empty  = ctl_q.tx_fifo & tx_lvl.empty;
        tx_evt.aempty = ctl_q.tx_fifo & tx_lvl.aempty;
        tx_evt.full   = ctl_q.tx_fifo & tx_lvl.full;
        tx_evt.afull  = ctl_q.tx_fifo & tx_lvl.afull;
        tx_evt.starve = tx_starve;
        tx_evt.ovf    = wr_tx & ctl_q.tx_fifo & tx_full;

        rx_evt.empty  = ctl_q.rx_fifo & rx_lvl.empty;
        rx_evt.aempty = ctl_q.rx_fifo & rx_lvl.aempty;
        rx_evt.full   = ctl_q.rx_fifo & rx_lvl.full;
        rx_evt.afull  = ctl_q.rx_fifo & rx_lvl.afull;
        rx_evt.starve = rd_rx & ctl_q.rx_fifo & rx_empty;
        rx_evt.ovf    = rx_push & rx_full;
    end

    assign evt      = {tx_evt, rx_evt};
    assign clr_mask = wr_clr ? wr_data[STAT_W-1:0] : '0;

    always_ff @(posedge clk) begin
        if (rst) stat_q <= '0;
        else     stat_q <= (stat_q & ~clr_mask) | evt;
    end

    assign irq = ien_q[STAT_W] & |(stat_q & ien_q[STAT_W-1:0]);

    assign tx_dma_req = tx_act & ctl_q.tx_dma & (32'(tx_cnt) < 32'(ctl_q.tx_thr));
    assign rx_dma_req = rx_act & ctl_q.rx_dma & ~rx_empty
                      & (32'(rx_cnt) >= 32'(ctl_q.rx_thr));

    always_comb begin
        case (reg_addr_e'(rd_addr))
            A_CTRL:     rd_data = RD_W'(ctl_q);
            A_RXDATA:   rd_data = {3'b000, ~rx_empty, rx_empty ? {SAMPLE_W{1'b0}} : rx_dout};
            A_IRQEN:    rd_data = RD_W'(ien_q);
            A_IRQSTAT:  rd_data = RD_W'(stat_q);
            A_FIFOSTAT: rd_data = {tx_lvl, rx_lvl, 6'(tx_cnt), 6'(rx_cnt)};
            default:    rd_data = '0;
        endcase
    end

    assert_gen_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (wr_ctl && ctl_q.en && (wr_data[1] || wr_data[2])) |=> ctl_q.en);

    assert_w1c_R9: assert property (@(posedge clk) disable iff (rst)
        ((clr_mask != '0) && ((evt & clr_mask) == '0)) |=> ((stat_q & $past(clr_mask)) == '0));

endmodule

// File: tb/pcm_port_test.sv
module pcm_port_test;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bit_tick = 1'b0, frame_sync = 1'b0, sdi = 1'b0;
    logic sdo;
    logic wr_en = 1'b0, rd_en = 1'b0;
    logic [2:0]  wr_addr = '0, rd_addr = '0;
    logic [18:0] wr_data = '0;
    logic [19:0] rd_data;
    logic tx_dma_req, rx_dma_req, irq;

    int total = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pcm_port uut (
        .clk(clk), .rst(rst), .bit_tick(bit_tick), .frame_sync(frame_sync),
        .sdi(sdi), .sdo(sdo), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_data(rd_data), .tx_dma_req(tx_dma_req),
        .rx_dma_req(rx_dma_req), .irq(irq)
    );

    // {tx_late, rx_late, tx word, rx word}
    localparam logic [33:0] VEC [6] = '{
        {1'b0, 1'b0, 16'hA5C3, 16'h3C5A},
        {1'b1, 1'b1, 16'h1234, 16'hFEDC},
        {1'b1, 1'b0, 16'h8001, 16'h7FFE},
        {1'b0, 1'b1, 16'h0F0F, 16'hC3A5},
        {1'b0, 1'b0, 16'h8000, 16'h0001},
        {1'b1, 1'b1, 16'hFFFF, 16'h0000}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [18:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [19:0] d);
        @(negedge clk);
        rd_addr = a; rd_en = (a == 3'd2);
        #1 d = rd_data;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic tick(input logic fs, input logic din, output logic dout);
        @(negedge clk);
        bit_tick = 1'b1; frame_sync = fs; sdi = din;
        @(negedge clk);
        bit_tick = 1'b0; frame_sync = 1'b0;
        dout = sdo;
    endtask

    task automatic frame(input logic txl, input logic rxl, input logic [15:0] rxw,
                         output logic [15:0] txw);
        int txo, rxo;
        logic o, din;
        txo = txl ? 1 : 0;
        rxo = rxl ? 1 : 0;
        txw = '0;
        for (int k = 0; k < 18; k++) begin
            din = (k >= rxo && k < rxo + 16) ? rxw[15-(k-rxo)] : 1'b0;
            tick(k == 0, din, o);
            if (k >= txo && k < txo + 16) txw[15-(k-txo)] = o;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        logic [19:0] d;
        logic [15:0] tw;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // Reset state
        rd(3'd0, d); chk("R4 reset ctrl", 32'(d), 32'h0);
        rd(3'd5, d); chk("R5 reset fifo status", 32'(d), 32'h33000);
        rd(3'd4, d); chk("R9 reset status", 32'(d), 32'h0);
        chk("R9 reset irq", 32'(irq), 32'h0);
        chk("R1 reset sdo", 32'(sdo), 32'h0);
        chk("R8 reset dma", 32'({tx_dma_req, rx_dma_req}), 32'h0);

        // Framing table: R1 R2 R3
        for (int i = 0; i < 6; i++) begin
            wr(3'd0, 19'h7 | (19'(VEC[i][32]) << 3) | (19'(VEC[i][33]) << 4));
            wr(3'd1, {3'b0, VEC[i][31:16]});
            frame(VEC[i][33], VEC[i][32], VEC[i][15:0], tw);
            chk($sformatf("R1 R2 tx word vec%0d", i), 32'(tw), 32'(VEC[i][31:16]));
            rd(3'd2, d);
            chk($sformatf("R3 R2 rx word vec%0d", i), 32'(d), {15'b0, 1'b1, VEC[i][15:0]});
        end

        // R4 global enable hold
        wr(3'd0, 19'h7); wr(3'd0, 19'h6);
        rd(3'd0, d); chk("R4 enable held", 32'(d), 32'h7);
        wr(3'd0, 19'h0);
        rd(3'd0, d); chk("R4 enable dropped", 32'(d), 32'h0);
        wr(3'd0, 19'h6);
        rd(3'd0, d); chk("R4 enable not set", 32'(d), 32'h6);
        wr(3'd0, 19'h0);

        // R10 disabled FIFO ignores writes and flushes
        wr(3'd0, 19'h3); wr(3'd1, 19'h1111);
        rd(3'd5, d); chk("R10 write ignored", 32'(d[11:6]), 32'd0);
        wr(3'd0, 19'h5);
        for (int i = 0; i < 3; i++) wr(3'd1, 19'(i));
        rd(3'd5, d); chk("R10 count before flush", 32'(d[11:6]), 32'd3);
        wr(3'd0, 19'h1);
        rd(3'd5, d); chk("R10 flushed", 32'(d[11:6]), 32'd0);

        // R5 R7 R8 TX fill
        wr(3'd6, 19'hFFF);
        wr(3'd0, 19'h8045);
        chk("R8 tx dma at count 0", 32'(tx_dma_req), 32'h1);
        for (int i = 0; i < 4; i++) wr(3'd1, 19'(i));
        chk("R8 tx dma at threshold", 32'(tx_dma_req), 32'h0);
        rd(3'd5, d); chk("R5 almost-empty at 4", 32'(d[17]), 32'h1);
        wr(3'd1, 19'h5);
        rd(3'd5, d); chk("R5 almost-empty at 5", 32'(d[17]), 32'h0);
        for (int i = 5; i < 27; i++) wr(3'd1, 19'(i));
        rd(3'd5, d); chk("R5 almost-full at 27", 32'(d[19]), 32'h0);
        wr(3'd1, 19'h1B);
        rd(3'd5, d); chk("R5 almost-full at 28", 32'(d[19]), 32'h1);
        for (int i = 28; i < 32; i++) wr(3'd1, 19'(i));
        rd(3'd5, d); chk("R5 full at 32", 32'({d[18], d[11:6]}), 32'h60);
        rd(3'd4, d); chk("R7 no tx overflow yet", 32'(d[6]), 32'h0);
        wr(3'd1, 19'h5555);
        rd(3'd5, d); chk("R7 tx count unchanged", 32'(d[11:6]), 32'd32);
        rd(3'd4, d); chk("R7 tx overflow flag", 32'(d[6]), 32'h1);
        frame(1'b0, 1'b0, 16'h0, tw);
        chk("R7 oldest word kept", 32'(tw), 32'h0);
        wr(3'd0, 19'h0);

        // R6 starvation, R9 interrupt
        wr(3'd0, 19'h5);
        wr(3'd3, 19'h1080);
        wr(3'd6, 19'hFFF);
        frame(1'b0, 1'b0, 16'h0, tw);
        chk("R6 zeros sent", 32'(tw), 32'h0);
        rd(3'd4, d); chk("R6 starve flag", 32'(d[7]), 32'h1);
        chk("R9 irq raised", 32'(irq), 32'h1);
        wr(3'd6, 19'h080);
        rd(3'd4, d); chk("R9 starve cleared", 32'(d[7]), 32'h0);
        chk("R9 irq dropped", 32'(irq), 32'h0);
        wr(3'd3, 19'h080);
        frame(1'b0, 1'b0, 16'h0, tw);
        chk("R9 no irq without master", 32'(irq), 32'h0);
        wr(3'd0, 19'h0);

        // R3 R7 R8 RX fill and overflow
        wr(3'd0, 19'h123);
        wr(3'd6, 19'hFFF);
        chk("R8 rx dma empty", 32'(rx_dma_req), 32'h0);
        frame(1'b0, 1'b0, 16'h1000, tw);
        chk("R8 rx dma below threshold", 32'(rx_dma_req), 32'h0);
        frame(1'b0, 1'b0, 16'h1001, tw);
        chk("R8 rx dma at threshold", 32'(rx_dma_req), 32'h1);
        for (int i = 2; i < 32; i++) frame(1'b0, 1'b0, 16'h1000 + 16'(i), tw);
        rd(3'd4, d); chk("R7 no rx overflow yet", 32'(d[0]), 32'h0);
        frame(1'b0, 1'b0, 16'hDEAD, tw);
        rd(3'd4, d); chk("R7 rx overflow flag", 32'(d[0]), 32'h1);
        rd(3'd5, d); chk("R5 rx full count", 32'({d[14], d[5:0]}), 32'h60);
        for (int i = 0; i < 32; i++) begin
            rd(3'd2, d);
            if (i == 0)  chk("R3 rx first word", 32'(d), 32'h11000);
            if (i == 31) chk("R7 rx last kept word", 32'(d), 32'h1101F);
        end
        rd(3'd2, d); chk("R3 empty read", 32'(d), 32'h0);
        rd(3'd4, d); chk("R3 rx starve flag", 32'(d[1]), 32'h1);

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule